// File: doc/BRIEF.md
# Ones'-Complement Word Checksum Unit

This block folds a stream of 16-bit words into a running sum and reports a check value when the last word of a block arrives. In its default sum mode it adds each word to an accumulator with ones'-complement arithmetic. Any carry out of the top bit is added back into bit 0 in the same clock, so the block takes one word per cycle. The check value it reports is the inverse of that sum, which is the word a sender appends to a block.

The same hardware checks a received block. The receiver streams every word through it, the appended check word included. The block raises `check_ok` when the total is all ones, so no stored copy of the checksum is needed for a compare. A second, lighter mode folds every byte of the stream together with XOR and reports the resulting parity byte. In that mode a block is valid when its parity byte comes out zero.

Words enter through a valid/ready handshake. A word is taken in any cycle where `in_valid` and `in_ready` are both high. The source must hold the word and `in_last` stable until that happens. The block lowers `in_ready` once it has taken a last word and keeps it low until the next `clear`, so no word of a following block can leak into a finished result. `clear` and `mode` are plain control pins.

Top module: `csum_unit`

## Requirements
- R1: After reset, `checksum_out` is 0x0000, `result_valid` and `check_ok` are 0, `in_ready` is 1, and the unit is in sum mode.
- R2: In sum mode (mode = 0), each accepted word is added to the accumulator as a 16-bit ones'-complement sum. A carry out of bit 15 is added into bit 0 in the same cycle, for example 0x8000 + 0x8000 = 0x0001 and 0xFFFF + 0xFFFF = 0xFFFF.
- R3: In sum mode, `checksum_out` is the bitwise inverse of the accumulated sum. An all-zero block gives 0xFFFF, and a sum of 0xFFFF gives 0x0000.
- R4: In sum mode, `check_ok` is 1 exactly when the accumulated sum is 0xFFFF. A block followed by its own checksum word passes, and the same block with one bit flipped fails.
- R5: In parity mode (mode = 1), `checksum_out[7:0]` is the XOR of the high byte and the low byte of every accepted word, and `checksum_out[15:8]` is 0. `check_ok` is 1 exactly when that byte is 0x00.
- R6: `in_ready` is 1 while a block is open and `clear` is low. It is 0 from the cycle after the last word is taken until `clear`. A word offered while `in_ready` is 0, including one offered in the same cycle as `clear`, is not added.
- R7: `result_valid` rises in the first cycle after the word marked `in_last` is accepted. `checksum_out` and `check_ok` hold their values until the next `clear`, and read 0 while `result_valid` is 0.
- R8: `clear` is synchronous. It zeroes the accumulator, drops `result_valid`, opens a new block and latches `mode`. A change of `mode` at any other time has no effect on the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start a new block, latching `mode` |
| mode | input | 1 | 0 = ones'-complement sum, 1 = byte XOR parity |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The unit can take a word this cycle |
| in_data | input | 16 | Word to accumulate |
| in_last | input | 1 | The offered word ends the block |
| checksum_out | output | 16 | Check value, valid while `result_valid` is 1 |
| result_valid | output | 1 | Result is ready and held |
| check_ok | output | 1 | Accumulated block is consistent |

## Verification
The assertions watch several rules on every cycle:
- taking a last word always raises `result_valid` on the next cycle;
- a raised result stays frozen until `clear`;
- `in_ready` stays low while a result is held;
- `clear` always drops the result;
- a ones'-complement addition with a nonzero operand never yields 0x0000.

Only the bench scenarios can show that the numbers are right. These cover:
- end-around carry on words such as 0x8000 and 0xFFFF pairs;
- both encodings of zero;
- pass and fail of appended checksums and parity bytes over random blocks;
- that words offered outside the handshake, and mode changes mid-block, leave the result untouched.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic {
    CS_MODE_SUM = 1'b0,
    CS_MODE_PAR = 1'b1
  } cs_mode_e;

  typedef enum logic {
    CS_ST_OPEN = 1'b0,
    CS_ST_DONE = 1'b1
  } cs_state_e;
endpackage

// File: rtl/csum_oc_add.sv
module csum_oc_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    // Fold the carry back in; a second carry cannot arise here.
    y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end

  // R2: a nonzero operand never produces the positive-zero encoding.
  always_comb begin
    if (!$isunknown({a, b}) && (a != '0 || b != '0)) begin
      a_r2_no_pos_zero: assert (y != '0);
    end
  end
endmodule

// File: rtl/csum_byte_fold.sv
module csum_byte_fold #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic [W-1:0] word,
  output logic [B-1:0] folded
);
  localparam int LANES = W / B;

  logic [B-1:0] part [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign part[g] = word[B-1:0];
      end else begin : g_rest
        assign part[g] = part[g-1] ^ word[g*B +: B];
      end
    end
  endgenerate

  assign folded = part[LANES-1];
endmodule

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic last,
  output logic open_q,
  output logic done_q
);
  cs_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_ST_OPEN;
    end else if (clear) begin
      st_q <= CS_ST_OPEN;
    end else if (take && last) begin
      st_q <= CS_ST_DONE;
    end
  end

  assign open_q = (st_q == CS_ST_OPEN);
  assign done_q = (st_q == CS_ST_DONE);

  // R7: accepting a last word closes the block on the next cycle.
  a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
    take && last && !clear |=> done_q);

  // R8: clear always reopens the block.
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> open_q);
endmodule

// File: rtl/csum_unit.sv
module csum_unit
  import csum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [DATA_W-1:0] checksum_out,
  output logic              result_valid,
  output logic              check_ok
);
  localparam int PAD_W = DATA_W - BYTE_W;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  cs_mode_e          mode_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] sum_nxt;
  logic [DATA_W-1:0] acc_nxt;
  logic [BYTE_W-1:0] par_byte;
  logic              take;
  logic              open_q;
  logic              done_q;

  assign in_ready = open_q && !clear;
  assign take     = in_valid && in_ready;

  csum_oc_add #(.W(DATA_W)) u_add (
    .a (acc_q),
    .b (in_data),
    .y (sum_nxt)
  );

  csum_byte_fold #(.W(DATA_W), .B(BYTE_W)) u_fold (
    .word   (acc_q),
    .folded (par_byte)
  );

  csum_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .take   (take),
    .last   (in_last),
    .open_q (open_q),
    .done_q (done_q)
  );

  always_comb begin
    if (mode_q == CS_MODE_SUM) acc_nxt = sum_nxt;
    else                       acc_nxt = acc_q ^ in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mode_q <= CS_MODE_SUM;
    end else if (clear) begin
      acc_q  <= '0;
      mode_q <= cs_mode_e'(mode);
    end else if (take) begin
      acc_q  <= acc_nxt;
    end
  end

  always_comb begin
    result_valid = done_q;
    checksum_out = '0;
    check_ok     = 1'b0;
    if (done_q) begin
      if (mode_q == CS_MODE_SUM) begin
        checksum_out = ~acc_q;
        check_ok     = (acc_q == ALL_ONES);
      end else begin
        checksum_out = {{PAD_W{1'b0}}, par_byte};
        check_ok     = (par_byte == '0);
      end
    end
  end

  // R7: a held result does not move until clear.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && !clear |=> result_valid && $stable(checksum_out) && $stable(check_ok));

  // R6: no word is taken while a result is held.
  a_r6_closed: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !in_ready);

  // R8: clear drops the result and blanks the outputs.
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !result_valid && checksum_out == '0 && !check_ok);

  // R4: a pass is only ever reported alongside a result.
  a_r4_ok_valid: assert property (@(posedge clk) disable iff (!rst_n)
    check_ok |-> result_valid);
endmodule

// File: tb/csum_unit_bench.sv
module csum_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [15:0] checksum_out;
  logic        result_valid;
  logic        check_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csum_unit u_csum_unit (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .checksum_out(checksum_out),
    .result_valid(result_valid), .check_ok(check_ok)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic start(input logic m);
    @(negedge clk);
    clear = 1'b1; mode = m;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic push(input logic [15:0] w, input logic last);
    int gap;
    gap = int'($urandom_range(0, 2));
    for (int i = 0; i < gap; i++) @(negedge clk);
    in_valid = 1'b1; in_data = w; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_data = $urandom();
  endtask

  task automatic expect_result(input string req, input logic [15:0] cs, input logic ok);
    check({req, " result_valid"}, {15'd0, result_valid}, 16'd1);
    check({req, " checksum_out"}, checksum_out, cs);
    check({req, " check_ok"}, {15'd0, check_ok}, {15'd0, ok});
  endtask

  logic [15:0] blk [24];

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state straight after reset
    check("R1 checksum_out", checksum_out, 16'h0000);
    check("R1 result_valid", {15'd0, result_valid}, 16'd0);
    check("R1 check_ok", {15'd0, check_ok}, 16'd0);
    check("R1 in_ready", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after release", {15'd0, in_ready}, 16'd1);

    // R1: default sum mode without any clear; R2 carry 0x8000+0x8000 -> 0x0001
    push(16'h8000, 1'b0);
    push(16'h8000, 1'b1);
    expect_result("R2 wrap", 16'hFFFE, 1'b0);
    check("R6 ready low after last", {15'd0, in_ready}, 16'd0);

    // R6: a word offered while closed is ignored
    in_valid = 1'b1; in_data = 16'h1234; in_last = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R6 ignored word", checksum_out, 16'hFFFE);
    check("R7 hold", {15'd0, result_valid}, 16'd1);

    // R2/R3/R4: 0xFFFF + 0xFFFF stays 0xFFFF, checksum is positive zero
    start(1'b0);
    check("R8 cleared valid", {15'd0, result_valid}, 16'd0);
    check("R7 blank output", checksum_out, 16'h0000);
    push(16'hFFFF, 1'b0);
    push(16'hFFFF, 1'b1);
    expect_result("R3 negative zero", 16'h0000, 1'b1);

    // R3: an all-zero block gives 0xFFFF and fails the check
    start(1'b0);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b1);
    expect_result("R3 positive zero", 16'hFFFF, 1'b0);
    // R4: the same block with its checksum appended passes
    start(1'b0);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b0);
    push(16'hFFFF, 1'b1);
    expect_result("R4 zero block verify", 16'h0000, 1'b1);

    // R6: a word offered in the same cycle as clear is dropped
    @(negedge clk);
    clear = 1'b1; mode = 1'b0; in_valid = 1'b1; in_data = 16'h0F0F; in_last = 1'b1;
    @(negedge clk);
    clear = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    push(16'h0001, 1'b1);
    expect_result("R6 clear drops word", 16'hFFFE, 1'b0);

    // R2/R3/R4: random blocks, generated then verified then corrupted
    for (int t = 0; t < 40; t++) begin
      int n;
      int bad;
      logic [15:0] s;
      logic [15:0] cs;
      n = int'($urandom_range(1, 20));
      s = 16'h0000;
      for (int i = 0; i < n; i++) begin
        blk[i] = (t % 5 == 0) ? 16'hFFFF - 16'($urandom_range(0, 3)) : 16'($urandom());
        s = oc_add(s, blk[i]);
      end
      cs = ~s;
      start(1'b0);
      for (int i = 0; i < n; i++) push(blk[i], i == n - 1);
      expect_result("R3 random checksum", cs, s == 16'hFFFF);
      start(1'b0);
      for (int i = 0; i < n; i++) push(blk[i], 1'b0);
      push(cs, 1'b1);
      expect_result("R4 random verify", 16'h0000, 1'b1);
      bad = int'($urandom_range(0, n - 1));
      blk[bad] = blk[bad] ^ (16'h1 << $urandom_range(0, 15));
      start(1'b0);
      for (int i = 0; i < n; i++) push(blk[i], 1'b0);
      push(cs, 1'b1);
      check("R4 corrupt fails", {15'd0, check_ok}, 16'd0);
    end

    // R5/R8: parity mode with mode toggled mid-block
    for (int t = 0; t < 25; t++) begin
      int n;
      logic [7:0] p;
      n = int'($urandom_range(1, 16));
      p = 8'h00;
      for (int i = 0; i < n; i++) begin
        blk[i] = 16'($urandom());
        p = p ^ blk[i][15:8] ^ blk[i][7:0];
      end
      start(1'b1);
      for (int i = 0; i < n; i++) begin
        mode = ~mode;
        push(blk[i], i == n - 1);
      end
      expect_result("R5 parity byte R8 mode held", {8'h00, p}, p == 8'h00);
      start(1'b1);
      for (int i = 0; i < n; i++) push(blk[i], 1'b0);
      push({8'h00, p}, 1'b1);
      expect_result("R5 parity verify", 16'h0000, 1'b1);
    end

    // R8: sum mode latched, then mode pin raised mid-block
    start(1'b0);
    mode = 1'b1;
    push(16'hF000, 1'b0);
    push(16'h2000, 1'b1);
    expect_result("R8 mode ignored", 16'hEFFE, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule